// File: doc/BRIEF.md
# Interrupt Priority Chain

This block arbitrates interrupt requests from several internal sources of one peripheral and places that peripheral in an external priority chain. Each source has a pending flag, set by a one-cycle event from its own datapath, and an in-service flag. Source 0 (the serial cell) always outranks source 1 (the DMA cell). The enable arriving from higher-priority devices passes through the sources in rank order and leaves as the enable for lower-priority devices. An active-low request output tells the host CPU that some source wants attention.

When the host acknowledges, the highest-ranked source whose pending flag is set and whose incoming enable is high takes service. Its in-service flag is set, and it returns an 8-bit vector on the read data port. The serial cell's vector carries a 3-bit status code, merged into either the low or the high bit group of its base. In no-vector mode the DMA cell takes service but does not drive the port. Software retires pending and in-service flags with a command code and a per-source select mask. Several instances are chained by wiring one instance's enable output to the next instance's enable input.

Top module: `irq_chain`

## Requirements
- R1: After reset no flag is set: `irq_n_o` is 1, `ie_out_o` equals `ie_in_i` and `rd_drive_o` is 0.
- R2: A pulse on `src_set_i[k]` sets that source's pending flag at the next clock edge. While `mie_i` is 0, `irq_n_o` stays 1.
- R3: `irq_n_o` is 0 only when some source k is pending, no source at rank 0..k is in service, `mie_i` is 1 and `ie_in_i` is 1.
- R4: `ie_out_o` is 0 whenever `ie_in_i` is 0 or any source is pending or in service, and it is 1 otherwise.
- R5: An acknowledge starts in the first cycle in which `iack_i` and `rd_i` are both 1 after a cycle in which they were not. At that edge, only the lowest-numbered source that is pending and sees a high incoming enable sets its in-service flag. If no source qualifies, no flag changes.
- R6: `rd_drive_o` is 1 only while `iack_i` and `rd_i` are both 1, starting one cycle after the acknowledge begins and only if a source took service.
- R7: The vector for source 1 is `vec_base_i[15:8]`. For source 0 it is `vec_base_i[7:0]` with `stat_i` written into bits 3:1 when `stat_hi_i` is 0, or into bits 6:4 when `stat_hi_i` is 1. Status and select are sampled when the acknowledge begins.
- R8: When `novec_i` is 1 and source 1 takes service, `rd_drive_o` stays 0 but the in-service flag is still set. Source 0 drives its vector regardless of `novec_i`.
- R9: With `cmd_valid_i` set, code 3'b001 clears the pending flags and code 3'b010 clears the in-service flags of the sources selected in `cmd_sel_i` (bit 0 is the serial cell, bit 1 is the DMA cell). Every other code has no effect. A set event in the same cycle wins over a clear.
- R10: In a chain of two instances, the lower instance gets no enable, raises no request and takes no acknowledge while the upper instance has a source pending or in service. It is released once the upper flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set_i | input | NSRC | Per-source event pulse that sets the pending flag |
| mie_i | input | 1 | Master interrupt enable |
| ie_in_i | input | 1 | Enable from higher-priority devices |
| ie_out_o | output | 1 | Enable to lower-priority devices |
| irq_n_o | output | 1 | Active-low interrupt request |
| iack_i | input | 1 | Interrupt acknowledge cycle marker |
| rd_i | input | 1 | Read strobe |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 3 | Command code (001 clear pending, 010 clear in-service) |
| cmd_sel_i | input | NSRC | Sources a command applies to |
| vec_base_i | input | NSRC*VEC_W | Base vector for each source, source k at bits k*VEC_W |
| stat_i | input | STAT_W | Serial-cell status code merged into its vector |
| stat_hi_i | input | 1 | 1 places the status in the high bit group, 0 in the low group |
| novec_i | input | 1 | DMA cell withholds its vector |
| rd_drive_o | output | 1 | Read data port is driven with a vector |
| rd_data_o | output | VEC_W | Vector, zero when not driven |

## Verification
Directed sequences check three situations that show whether the rank order is right. Both sources pending at once must give the serial vector. A nested pending source must stay masked while a higher one is in service. A two-instance chain must keep the lower instance silent until the upper instance has cleared both its flags. Further cases target specific faults: a held acknowledge must not start a second one, an ignored command code must leave state untouched, and a same-cycle set and clear must keep the flag set, which exposes a reversed priority between them. A long seeded random run mixes events, commands, enable drops and acknowledges of varying length against a bench model, which covers orderings the directed cases do not reach.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
   localparam int CMD_W = 3;
   typedef enum logic [CMD_W-1:0] {
      CMD_NONE    = 3'b000,
      CMD_CLR_IP  = 3'b001,
      CMD_CLR_IUS = 3'b010
   } irq_cmd_e;
endpackage

// File: rtl/irq_chain_link.sv
// One rank of the chain: pending and in-service flags plus enable pass-through.
module irq_chain_link (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_ip_i,
   input  logic clr_ius_i,
   input  logic ack_stb_i,
   input  logic en_in_i,
   output logic en_out_o,
   output logic ip_o,
   output logic ius_o,
   output logic win_o
);
   logic ip_q;
   logic ius_q;

   assign win_o    = ip_q & en_in_i;
   assign en_out_o = en_in_i & ~ip_q & ~ius_q;
   assign ip_o     = ip_q;
   assign ius_o    = ius_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ip_q  <= 1'b0;
         ius_q <= 1'b0;
      end else begin
         if (set_i)
            ip_q <= 1'b1;
         else if (clr_ip_i)
            ip_q <= 1'b0;
         if (ack_stb_i && win_o)
            ius_q <= 1'b1;
         else if (clr_ius_i)
            ius_q <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_chain_vec.sv
// Vector former: picks the winner's base and optionally merges status bits.
module irq_chain_vec #(
   parameter int NSRC       = 2,
   parameter int VEC_W      = 8,
   parameter int STAT_W     = 3,
   parameter int STAT_SRC   = 0,
   parameter bit MERGE_STAT = 1'b1,
   localparam int IDX_W     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic [NSRC*VEC_W-1:0] base_i,
   input  logic [IDX_W-1:0]      sel_i,
   input  logic [STAT_W-1:0]     stat_i,
   input  logic                  stat_hi_i,
   output logic [VEC_W-1:0]      vec_o
);
   localparam int LO_LSB = 1;
   localparam int HI_LSB = 1 + STAT_W;

   if (MERGE_STAT) begin : g_merge
      always_comb begin
         vec_o = base_i[sel_i*VEC_W +: VEC_W];
         if (sel_i == IDX_W'(STAT_SRC)) begin
            if (stat_hi_i)
               vec_o[HI_LSB +: STAT_W] = stat_i;
            else
               vec_o[LO_LSB +: STAT_W] = stat_i;
         end
      end
   end else begin : g_plain
      assign vec_o = base_i[sel_i*VEC_W +: VEC_W];
   end
endmodule

// File: rtl/irq_chain.sv
module irq_chain #(
   parameter int NSRC       = 2,
   parameter int VEC_W      = 8,
   parameter int STAT_W     = 3,
   parameter int STAT_SRC   = 0,
   parameter int NOVEC_SRC  = 1,
   parameter bit MERGE_STAT = 1'b1,
   localparam int IDX_W     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NSRC-1:0]       src_set_i,
   input  logic                  mie_i,
   input  logic                  ie_in_i,
   output logic                  ie_out_o,
   output logic                  irq_n_o,
   input  logic                  iack_i,
   input  logic                  rd_i,
   input  logic                  cmd_valid_i,
   input  logic [2:0]            cmd_code_i,
   input  logic [NSRC-1:0]       cmd_sel_i,
   input  logic [NSRC*VEC_W-1:0] vec_base_i,
   input  logic [STAT_W-1:0]     stat_i,
   input  logic                  stat_hi_i,
   input  logic                  novec_i,
   output logic                  rd_drive_o,
   output logic [VEC_W-1:0]      rd_data_o
);
   import irq_chain_pkg::*;

   if (NSRC < 2) begin : g_bad_nsrc
      $error("irq_chain: NSRC must be at least 2");
   end
   if (2*STAT_W + 1 > VEC_W) begin : g_bad_stat
      $error("irq_chain: both status groups must fit inside the vector");
   end
   if (STAT_SRC >= NSRC || NOVEC_SRC >= NSRC) begin : g_bad_src
      $error("irq_chain: source index parameter out of range");
   end

   logic [NSRC:0]   en;
   logic [NSRC-1:0] ip_v;
   logic [NSRC-1:0] ius_v;
   logic [NSRC-1:0] win_v;
   logic [NSRC-1:0] clr_ip;
   logic [NSRC-1:0] clr_ius;
   logic            ack_act;
   logic            ack_q;
   logic            ack_stb;

   assign en[0]    = ie_in_i;
   assign ie_out_o = en[NSRC];
   assign ack_act  = iack_i & rd_i;
   assign ack_stb  = ack_act & ~ack_q;

   for (genvar k = 0; k < NSRC; k++) begin : g_rank
      assign clr_ip[k]  = cmd_valid_i && (cmd_code_i == CMD_CLR_IP)  && cmd_sel_i[k];
      assign clr_ius[k] = cmd_valid_i && (cmd_code_i == CMD_CLR_IUS) && cmd_sel_i[k];
      irq_chain_link u_link (
         .clk       (clk),
         .rst_n     (rst_n),
         .set_i     (src_set_i[k]),
         .clr_ip_i  (clr_ip[k]),
         .clr_ius_i (clr_ius[k]),
         .ack_stb_i (ack_stb),
         .en_in_i   (en[k]),
         .en_out_o  (en[k+1]),
         .ip_o      (ip_v[k]),
         .ius_o     (ius_v[k]),
         .win_o     (win_v[k])
      );
   end

   // Request: pending source not shadowed by in-service at or above its rank.
   logic req_any;
   always_comb begin
      logic blk;
      blk     = 1'b0;
      req_any = 1'b0;
      for (int k = 0; k < NSRC; k++) begin
         blk = blk | ius_v[k];
         if (ip_v[k] && !blk)
            req_any = 1'b1;
      end
   end
   assign irq_n_o = ~(req_any & mie_i & ie_in_i);

   // Winner index (lowest rank wins; the chain already makes it unique).
   logic [IDX_W-1:0] win_idx;
   logic             win_any;
   always_comb begin
      win_idx = '0;
      win_any = 1'b0;
      for (int k = NSRC-1; k >= 0; k--) begin
         if (win_v[k]) begin
            win_idx = IDX_W'(k);
            win_any = 1'b1;
         end
      end
   end

   logic [VEC_W-1:0] vec_new;
   irq_chain_vec #(
      .NSRC       (NSRC),
      .VEC_W      (VEC_W),
      .STAT_W     (STAT_W),
      .STAT_SRC   (STAT_SRC),
      .MERGE_STAT (MERGE_STAT)
   ) u_vec (
      .base_i    (vec_base_i),
      .sel_i     (win_idx),
      .stat_i    (stat_i),
      .stat_hi_i (stat_hi_i),
      .vec_o     (vec_new)
   );

   logic             drv_q;
   logic [VEC_W-1:0] vec_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
         drv_q <= 1'b0;
         vec_q <= '0;
      end else begin
         ack_q <= ack_act;
         if (ack_stb) begin
            drv_q <= win_any && !(novec_i && (win_idx == IDX_W'(NOVEC_SRC)));
            vec_q <= vec_new;
         end else if (!ack_act) begin
            drv_q <= 1'b0;
         end
      end
   end

   assign rd_drive_o = drv_q & ack_act;
   assign rd_data_o  = rd_drive_o ? vec_q : '0;
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
   parameter int NSRC = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NSRC-1:0] ip_v,
   input logic [NSRC-1:0] ius_v,
   input logic            ack_stb,
   input logic [NSRC-1:0] src_set_i,
   input logic            mie_i,
   input logic            ie_in_i,
   input logic            ie_out_o,
   input logic            irq_n_o,
   input logic            iack_i,
   input logic            rd_i,
   input logic            cmd_valid_i,
   input logic [2:0]      cmd_code_i,
   input logic [NSRC-1:0] cmd_sel_i,
   input logic            rd_drive_o
);
   p_eo_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie_in_i || ip_v != '0 || ius_v != '0) |-> !ie_out_o);

   p_eo_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ie_in_i && ip_v == '0 && ius_v == '0) |-> ie_out_o);

   p_irq_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie_in_i || !mie_i) |-> irq_n_o);

   p_top_ius_masks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ius_v[0] |-> irq_n_o);

   p_drive_in_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_drive_o |-> (iack_i && rd_i));

   p_single_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> ($countones(ius_v & ~$past(ius_v)) <= 1));

   for (genvar k = 0; k < NSRC; k++) begin : g_src
      p_grant_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ius_v[k]) |-> $past(ack_stb && ip_v[k]));

      p_set_ip_r2: assert property (@(posedge clk) disable iff (!rst_n)
         src_set_i[k] |=> ip_v[k]);

      p_clr_ip_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_valid_i && cmd_code_i == 3'b001 && cmd_sel_i[k] && !src_set_i[k])
         |=> !ip_v[k]);
   end
endmodule

bind irq_chain irq_chain_chk #(.NSRC(NSRC)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ip_v        (ip_v),
   .ius_v       (ius_v),
   .ack_stb     (ack_stb),
   .src_set_i   (src_set_i),
   .mie_i       (mie_i),
   .ie_in_i     (ie_in_i),
   .ie_out_o    (ie_out_o),
   .irq_n_o     (irq_n_o),
   .iack_i      (iack_i),
   .rd_i        (rd_i),
   .cmd_valid_i (cmd_valid_i),
   .cmd_code_i  (cmd_code_i),
   .cmd_sel_i   (cmd_sel_i),
   .rd_drive_o  (rd_drive_o)
);

// File: tb/irq_chain_tb.sv
`timescale 1ns/1ps
module irq_chain_tb;
   localparam logic [15:0] BASE_U = 16'h9080;
   localparam logic [15:0] BASE_L = 16'hB0A0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int total = 0;
   int bad   = 0;

   logic [1:0] set_u = '0, set_l = '0;
   logic       mie = 1'b1, ie_top = 1'b1, iack = 1'b0, rd = 1'b0;
   logic       cv_u = 1'b0, cv_l = 1'b0;
   logic [2:0] cc_u = '0, cc_l = '0;
   logic [1:0] cs_u = '0, cs_l = '0;
   logic [2:0] stat = '0;
   logic       shi = 1'b0, nov = 1'b0;

   logic       eo_u, eo_l, irqn_u, irqn_l, drv_u, drv_l;
   logic [7:0] data_u, data_l;

   irq_chain #(.NSRC(2), .VEC_W(8), .STAT_W(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .src_set_i(set_u), .mie_i(mie),
      .ie_in_i(ie_top), .ie_out_o(eo_u), .irq_n_o(irqn_u),
      .iack_i(iack), .rd_i(rd), .cmd_valid_i(cv_u), .cmd_code_i(cc_u),
      .cmd_sel_i(cs_u), .vec_base_i(BASE_U), .stat_i(stat),
      .stat_hi_i(shi), .novec_i(nov), .rd_drive_o(drv_u), .rd_data_o(data_u));

   irq_chain #(.NSRC(2), .VEC_W(8), .STAT_W(3)) u_dut_lo (
      .clk(clk), .rst_n(rst_n), .src_set_i(set_l), .mie_i(mie),
      .ie_in_i(eo_u), .ie_out_o(eo_l), .irq_n_o(irqn_l),
      .iack_i(iack), .rd_i(rd), .cmd_valid_i(cv_l), .cmd_code_i(cc_l),
      .cmd_sel_i(cs_l), .vec_base_i(BASE_L), .stat_i(stat),
      .stat_hi_i(shi), .novec_i(nov), .rd_drive_o(drv_l), .rd_data_o(data_l));

   // Bench model, index 0 = upper instance, 1 = lower instance.
   bit [1:0] m_ip  [2];
   bit [1:0] m_ius [2];
   bit       m_drv [2];
   bit [7:0] m_vec [2];
   bit       m_ackq;

   function automatic bit [1:0] f_win(bit [1:0] ip, bit [1:0] ius, bit ein);
      bit [1:0] w;
      bit en;
      en = ein;
      for (int k = 0; k < 2; k++) begin
         w[k] = ip[k] & en;
         en = en & ~ip[k] & ~ius[k];
      end
      return w;
   endfunction

   function automatic bit f_eo(bit [1:0] ip, bit [1:0] ius, bit ein);
      return ein && ip == 2'b00 && ius == 2'b00;
   endfunction

   function automatic bit f_irqn(bit [1:0] ip, bit [1:0] ius, bit ein, bit m);
      bit blk, req;
      blk = 1'b0;
      req = 1'b0;
      for (int k = 0; k < 2; k++) begin
         blk = blk | ius[k];
         if (ip[k] && !blk) req = 1'b1;
      end
      return !(req && m && ein);
   endfunction

   function automatic bit [7:0] f_vec(bit [15:0] base, int idx, bit [2:0] st, bit hi);
      bit [7:0] v;
      v = (idx == 0) ? base[7:0] : base[15:8];
      if (idx == 0) begin
         if (hi) v[6:4] = st;
         else    v[3:1] = st;
      end
      return v;
   endfunction

   task automatic chk1(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_check();
      bit eo_ue;
      eo_ue = f_eo(m_ip[0], m_ius[0], ie_top);
      chk1("R4 ie_out upper", eo_u, eo_ue);
      chk1("R4 ie_out lower", eo_l, f_eo(m_ip[1], m_ius[1], eo_ue));
      chk1("R3 irq_n upper", irqn_u, f_irqn(m_ip[0], m_ius[0], ie_top, mie));
      chk1("R3 irq_n lower", irqn_l, f_irqn(m_ip[1], m_ius[1], eo_ue, mie));
      chk1("R6 drive upper", drv_u, m_drv[0] & iack & rd);
      chk1("R6 drive lower", drv_l, m_drv[1] & iack & rd);
      if (m_drv[0] && iack && rd) chk8("R7 vector upper", data_u, m_vec[0]);
      if (m_drv[1] && iack && rd) chk8("R7 vector lower", data_l, m_vec[1]);
   endtask

   task automatic model_update();
      bit act, stb;
      bit ein [2];
      act = iack & rd;
      stb = act & ~m_ackq;
      ein[0] = ie_top;
      ein[1] = f_eo(m_ip[0], m_ius[0], ie_top);
      for (int i = 0; i < 2; i++) begin
         bit [1:0] w, st, cs;
         bit cv;
         bit [2:0] cc;
         int idx;
         w  = f_win(m_ip[i], m_ius[i], ein[i]);
         st = (i == 0) ? set_u : set_l;
         cv = (i == 0) ? cv_u : cv_l;
         cc = (i == 0) ? cc_u : cc_l;
         cs = (i == 0) ? cs_u : cs_l;
         for (int k = 0; k < 2; k++) begin
            if (st[k]) m_ip[i][k] = 1'b1;
            else if (cv && cc == 3'b001 && cs[k]) m_ip[i][k] = 1'b0;
            if (stb && w[k]) m_ius[i][k] = 1'b1;
            else if (cv && cc == 3'b010 && cs[k]) m_ius[i][k] = 1'b0;
         end
         if (stb) begin
            idx = w[0] ? 0 : 1;
            m_drv[i] = (w != 2'b00) && !(idx == 1 && nov);
            m_vec[i] = f_vec((i == 0) ? BASE_U : BASE_L, idx, stat, shi);
         end else if (!act) begin
            m_drv[i] = 1'b0;
         end
      end
      m_ackq = act;
   endtask

   // Called at a falling edge with inputs already set; returns at the next falling edge.
   task automatic step();
      #1;
      model_check();
      @(posedge clk);
      model_update();
      @(negedge clk);
   endtask

   task automatic cmd_u(input logic [2:0] code, input logic [1:0] sel);
      cv_u = 1'b1; cc_u = code; cs_u = sel;
      step();
      cv_u = 1'b0;
   endtask

   task automatic cmd_l(input logic [2:0] code, input logic [1:0] sel);
      cv_l = 1'b1; cc_l = code; cs_l = sel;
      step();
      cv_l = 1'b0;
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      #1000000;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < 2; i++) begin
         m_ip[i] = '0; m_ius[i] = '0; m_drv[i] = 1'b0; m_vec[i] = '0;
      end
      m_ackq = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk1("R1 irq_n upper", irqn_u, 1'b1);
      chk1("R1 irq_n lower", irqn_l, 1'b1);
      chk1("R1 ie_out upper", eo_u, 1'b1);
      chk1("R1 ie_out lower", eo_l, 1'b1);
      chk1("R1 drive", drv_u | drv_l, 1'b0);
      @(negedge clk);

      // DMA source pends, enable chain closes
      set_u = 2'b10; step(); set_u = 2'b00;
      chk1("R2 irq_n after set", irqn_u, 1'b0);
      chk1("R4 ie_out upper pending", eo_u, 1'b0);
      chk1("R4 ie_out lower pending", eo_l, 1'b0);
      mie = 1'b0; step();
      chk1("R2 irq_n with mie off", irqn_u, 1'b1);
      mie = 1'b1;

      // both pending, serial wins, status in low group
      set_u = 2'b01; stat = 3'b101; shi = 1'b0; step(); set_u = 2'b00;
      iack = 1'b1; rd = 1'b1; step();
      chk1("R5 serial drives", drv_u, 1'b1);
      chk8("R7 serial vector low group", data_u, 8'h8A);
      chk1("R10 lower silent", drv_l, 1'b0);
      step();
      chk8("R5 held ack keeps vector", data_u, 8'h8A);
      iack = 1'b0; rd = 1'b0; step();
      chk1("R6 drive drops", drv_u, 1'b0);
      chk1("R3 serial in service masks DMA", irqn_u, 1'b1);

      // commands
      cmd_u(3'b001, 2'b01);
      chk1("R3 still masked by in-service", irqn_u, 1'b1);
      cmd_u(3'b010, 2'b01);
      chk1("R9 in-service cleared releases DMA", irqn_u, 1'b0);
      cmd_u(3'b011, 2'b11);
      chk1("R9 unknown code no effect irq", irqn_u, 1'b0);
      chk1("R9 unknown code no effect enable", eo_u, 1'b0);
      cmd_u(3'b000, 2'b11);
      chk1("R9 code 000 no effect", irqn_u, 1'b0);

      // no-vector DMA acknowledge
      nov = 1'b1; iack = 1'b1; rd = 1'b1; step();
      chk1("R8 DMA silent in no-vector", drv_u, 1'b0);
      iack = 1'b0; rd = 1'b0; step();
      chk1("R5 DMA took service", irqn_u, 1'b1);
      cmd_u(3'b001, 2'b10);
      cmd_u(3'b010, 2'b10);
      chk1("R4 chain open when empty", eo_u, 1'b1);

      // two-instance chain
      set_l = 2'b01; step(); set_l = 2'b00;
      chk1("R10 lower requests when upper idle", irqn_l, 1'b0);
      set_u = 2'b01; step(); set_u = 2'b00;
      chk1("R10 lower masked by upper pending", irqn_l, 1'b1);
      iack = 1'b1; rd = 1'b1; step();
      chk1("R8 serial drives despite no-vector", drv_u, 1'b1);
      chk8("R7 upper vector", data_u, 8'h8A);
      chk1("R10 lower not acknowledged", drv_l, 1'b0);
      iack = 1'b0; rd = 1'b0; step();
      cmd_u(3'b001, 2'b01);
      chk1("R10 lower masked by upper in-service", irqn_l, 1'b1);
      cmd_u(3'b010, 2'b01);
      chk1("R10 lower released", irqn_l, 1'b0);
      shi = 1'b1; nov = 1'b0; iack = 1'b1; rd = 1'b1; step();
      chk1("R10 lower drives", drv_l, 1'b1);
      chk8("R7 lower vector high group", data_l, 8'hD0);
      chk1("R10 upper silent", drv_u, 1'b0);
      iack = 1'b0; rd = 1'b0; step();
      cmd_l(3'b001, 2'b01);
      cmd_l(3'b010, 2'b01);

      // set wins over clear in one cycle
      set_u = 2'b01; cv_u = 1'b1; cc_u = 3'b001; cs_u = 2'b01; step();
      set_u = 2'b00; cv_u = 1'b0;
      chk1("R9 set beats clear", irqn_u, 1'b0);
      cmd_u(3'b001, 2'b01);
      chk1("R9 clear pending", irqn_u, 1'b1);

      // acknowledge with nothing pending
      iack = 1'b1; rd = 1'b1; step();
      chk1("R5 empty ack no drive upper", drv_u, 1'b0);
      chk1("R5 empty ack no drive lower", drv_l, 1'b0);
      iack = 1'b0; rd = 1'b0; step();

      // seeded random traffic
      for (int n = 0; n < 3000; n++) begin
         set_u  = ($urandom_range(7) == 0) ? 2'($urandom_range(3)) : 2'b00;
         set_l  = ($urandom_range(7) == 0) ? 2'($urandom_range(3)) : 2'b00;
         cv_u   = ($urandom_range(4) == 0);
         cv_l   = ($urandom_range(4) == 0);
         cc_u   = 3'($urandom_range(3));
         cc_l   = 3'($urandom_range(3));
         cs_u   = 2'($urandom_range(3));
         cs_l   = 2'($urandom_range(3));
         mie    = ($urandom_range(9) != 0);
         ie_top = ($urandom_range(11) != 0);
         stat   = 3'($urandom_range(7));
         shi    = 1'($urandom_range(1));
         nov    = ($urandom_range(2) == 0);
         if (!iack && $urandom_range(5) == 0) begin
            iack = 1'b1; rd = 1'b1;
         end else if (iack && $urandom_range(2) == 0) begin
            iack = 1'b0; rd = 1'b0;
         end else if (iack) begin
            rd = ($urandom_range(5) != 0);
         end
         step();
      end
      set_u = '0; set_l = '0; cv_u = 1'b0; cv_l = 1'b0; iack = 1'b0; rd = 1'b0;
      step();

      summary();
      $finish;
   end
endmodule